// File: doc/BRIEF.md
# Receive DMA Channel Controller

This channel takes bytes from a serial receiver and stores them one at a time into a circular buffer in memory. A four-entry FIFO sits between the receiver and the memory write port. The FIFO also holds end-of-frame and abort markers in their place in the byte stream, so a marker is always handled after the data bytes that came before it.

Software sets up the channel through a small register write port. The registers hold the segment, the buffer base and bound, the address pointer, the reload byte count and a control word. The control word selects one of four receive modes, turns the channel on or off, and enables each interrupt source. In framed-packet mode, each packet gets a two-byte header slot in front of its data. When the packet ends or is aborted, the slot is filled with the byte count and the status. In periodic mode, a working counter is reloaded by hardware, so a pending flag is raised once every n stored bytes. The character-timeout and character-match modes only store bytes; the timing and comparison logic for those modes lives outside this block. Software reads the current pointer from `curPtr` to work out how many bytes have been stored.

Top module: `rx_dma_channel`

## Requirements
- R1: After reset, `memReq`, `irq` and `pendFlags` are 0 and `curPtr` is 0.
- R2: Register writes use `cfgAddr`. Address 0 is the control word: bits[1:0] mode (0 framed, 1 periodic, 2 timeout, 3 match), bit 2 run, bits[5:3] enables for pending flags 0..2. Address 1 is the segment, 2 the base, 3 the bound, 4 the pointer, 5 the reload count and 6 the pending clear. Each memory write uses the address {segment, pointer}.
- R3: Once `memReq` is raised, `memAddr` and `memData` hold steady until a cycle with `memAck` high. That cycle completes exactly one byte write.
- R4: After a write at the bound address, the next address used is the base. Otherwise the address goes up by one.
- R5: In framed mode, when a packet starts, two addresses are reserved at the pointer for a header. The packet's data bytes are written after them.
- R6: In framed mode, an end or abort marker causes two writes. The first writes the packet's data byte count (modulo 256) at the first header address. The second writes the status byte (bit 0 = 1 if aborted) at the next address. Pending flag 0 is then set.
- R7: In periodic mode, writing the reload count n (n > 0) loads the working counter. Pending flag 1 is set after every n-th stored data byte, and the counter reloads by itself.
- R8: While the run bit is 0, no memory write starts and received bytes wait in the FIFO. Setting the run bit resumes the writes in order.
- R9: A byte that arrives while the FIFO holds four entries is dropped, and pending flag 2 (overrun) is set.
- R10: Pending flags stay set until software writes 1 to the matching bit at address 6. `irq` is the OR of the pending flags whose enable bits are set.
- R11: In timeout and match modes, data bytes are written one after another with no header, and end or abort markers are discarded without any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxValid | input | 1 | Receiver presents an entry |
| rxData | input | 8 | Received byte |
| rxEnd | input | 1 | Entry is an end-of-packet marker |
| rxAbort | input | 1 | Entry is an abort marker (takes precedence over rxEnd) |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWdata | input | 16 | Register write data |
| memAck | input | 1 | Memory accepts the current write |
| memReq | output | 1 | Byte write request |
| memAddr | output | 24 | Write address {segment, pointer} |
| memData | output | 8 | Write data |
| irq | output | 1 | Interrupt |
| pendFlags | output | 3 | Pending flags: 0 packet end, 1 periodic, 2 overrun |
| curPtr | output | 16 | Current address pointer |

## Verification
Some properties are checked on every cycle. The write request must hold its address and data until it is acknowledged. Each pending flag stays set unless it is cleared by writing 1. A push into a full FIFO must raise the overrun flag. The FIFO level must never exceed its depth. The interrupt may only be raised while some flag is pending. Other behaviours show only in the bench's scenarios, which compare every memory write against a scoreboard. These are the header contents and their placement, the wrap from bound to base, the exact byte on which the periodic flag rises, markers being discarded outside framed mode, and which bytes survive an overrun.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef enum logic [1:0] {
    MODE_FRAMED  = 2'd0,
    MODE_PERIOD  = 2'd1,
    MODE_TIMEOUT = 2'd2,
    MODE_MATCH   = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_END   = 2'd1,
    KIND_ABORT = 2'd2
  } kind_t;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_HDR0 = 2'd1,
    SEL_HDR1 = 2'd2
  } sel_t;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_SEG   = 3'd1;
  localparam logic [2:0] ADR_BASE  = 3'd2;
  localparam logic [2:0] ADR_BOUND = 3'd3;
  localparam logic [2:0] ADR_PTR   = 3'd4;
  localparam logic [2:0] ADR_COUNT = 3'd5;
  localparam logic [2:0] ADR_PEND  = 3'd6;

  localparam int NUM_PEND = 3;

  typedef struct packed {
    logic memReq;
    sel_t addrSel;
    logic pop;
    logic stepPtr;
    logic countByte;
    logic reserve;
    logic finishPkt;
  } strobe_t;
endpackage

// File: rtl/rx_dma_ctrl.sv
module rx_dma_ctrl
  import rx_dma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    memAck,
  input  logic    fifoEmpty,
  input  kind_t   headKind,
  input  logic    inPkt,
  input  mode_t   mode,
  input  logic    runEn,
  output strobe_t stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_HCNT, ST_HSTAT} state_t;
  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb = '0;
    stb.addrSel = SEL_PTR;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (runEn && !fifoEmpty) begin
          if (mode == MODE_FRAMED && !inPkt) begin
            stb.reserve = 1'b1;
          end else if (headKind == KIND_DATA) begin
            nextState = ST_DATA;
          end else if (mode == MODE_FRAMED) begin
            nextState = ST_HCNT;
          end else begin
            stb.pop = 1'b1;
          end
        end
      end
      ST_DATA: begin
        stb.memReq = 1'b1;
        if (memAck) begin
          stb.pop = 1'b1;
          stb.stepPtr = 1'b1;
          stb.countByte = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_HCNT: begin
        stb.memReq = 1'b1;
        stb.addrSel = SEL_HDR0;
        if (memAck) nextState = ST_HSTAT;
      end
      ST_HSTAT: begin
        stb.memReq = 1'b1;
        stb.addrSel = SEL_HDR1;
        if (memAck) begin
          stb.pop = 1'b1;
          stb.finishPkt = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rx_dma_dp.sv
module rx_dma_dp
  import rx_dma_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int PTR_W = 16,
  parameter int REG_W = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxValid,
  input  logic [7:0]               rxData,
  input  logic                     rxEnd,
  input  logic                     rxAbort,
  input  logic                     cfgWe,
  input  logic [2:0]               cfgAddr,
  input  logic [REG_W-1:0]         cfgWdata,
  input  strobe_t                  stb,
  output kind_t                    headKind,
  output logic                     fifoEmpty,
  output logic                     inPkt,
  output mode_t                    mode,
  output logic                     runEn,
  output logic [SEG_W+PTR_W-1:0]   memAddr,
  output logic [7:0]               memData,
  output logic                     irq,
  output logic [NUM_PEND-1:0]      pendFlags,
  output logic [PTR_W-1:0]         curPtr,
  output logic [LVL_W-1:0]         fifoLevel
);
  localparam int ENT_W = 10;

  // Receive FIFO: each entry carries a kind tag and the byte
  logic [ENT_W-1:0] fifoMem [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic             fifoFull, doPush;
  kind_t            inKind;

  assign fifoFull  = (fifoLevel == LVL_W'(DEPTH));
  assign fifoEmpty = (fifoLevel == '0);
  assign doPush    = rxValid && !fifoFull;
  assign inKind    = rxAbort ? KIND_ABORT : (rxEnd ? KIND_END : KIND_DATA);
  assign headKind  = kind_t'(fifoMem[rdIdx][9:8]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      fifoLevel <= '0;
    end else begin
      if (doPush) wrIdx <= (wrIdx == IDX_W'(DEPTH - 1)) ? '0 : wrIdx + 1'b1;
      if (stb.pop) rdIdx <= (rdIdx == IDX_W'(DEPTH - 1)) ? '0 : rdIdx + 1'b1;
      fifoLevel <= fifoLevel + LVL_W'(doPush) - LVL_W'(stb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrIdx] <= {inKind, rxData};
  end

  // Software registers
  logic [5:0]          ctrlReg;
  logic [SEG_W-1:0]    segReg;
  logic [PTR_W-1:0]    baseReg, boundReg, ptrReg, hdrPtr;
  logic [CNT_W-1:0]    reloadReg, workCnt;
  logic [7:0]          pktCnt;
  logic [NUM_PEND-1:0] pendSet, pendClr;

  assign mode  = mode_t'(ctrlReg[1:0]);
  assign runEn = ctrlReg[2];

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p,
                                                input logic [PTR_W-1:0] lo,
                                                input logic [PTR_W-1:0] hi);
    return (p == hi) ? lo : p + 1'b1;
  endfunction

  logic regWr;
  assign regWr = cfgWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      segReg    <= '0;
      baseReg   <= '0;
      boundReg  <= '0;
      reloadReg <= '0;
    end else if (regWr) begin
      unique case (cfgAddr)
        ADR_CTRL:  ctrlReg   <= cfgWdata[5:0];
        ADR_SEG:   segReg    <= cfgWdata[SEG_W-1:0];
        ADR_BASE:  baseReg   <= cfgWdata[PTR_W-1:0];
        ADR_BOUND: boundReg  <= cfgWdata[PTR_W-1:0];
        ADR_COUNT: reloadReg <= cfgWdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // Pointer, header slot and packet state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg <= '0;
      hdrPtr <= '0;
      inPkt  <= 1'b0;
      pktCnt <= '0;
    end else begin
      if (regWr && cfgAddr == ADR_PTR) begin
        ptrReg <= cfgWdata[PTR_W-1:0];
      end else if (stb.reserve) begin
        ptrReg <= advance(advance(ptrReg, baseReg, boundReg), baseReg, boundReg);
      end else if (stb.stepPtr) begin
        ptrReg <= advance(ptrReg, baseReg, boundReg);
      end
      if (stb.reserve) begin
        hdrPtr <= ptrReg;
        inPkt  <= 1'b1;
        pktCnt <= '0;
      end else begin
        if (stb.countByte) pktCnt <= pktCnt + 1'b1;
        if (stb.finishPkt) inPkt <= 1'b0;
      end
    end
  end

  // Periodic working counter
  logic periodHit;
  assign periodHit = stb.countByte && mode == MODE_PERIOD && workCnt == CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workCnt <= '0;
    end else if (regWr && cfgAddr == ADR_COUNT) begin
      workCnt <= cfgWdata[CNT_W-1:0];
    end else if (stb.countByte && mode == MODE_PERIOD && workCnt != '0) begin
      workCnt <= periodHit ? reloadReg : workCnt - 1'b1;
    end
  end

  // Pending flags: set wins over a same-cycle clear
  assign pendSet = {rxValid && fifoFull, periodHit, stb.finishPkt};
  assign pendClr = (regWr && cfgAddr == ADR_PEND) ? cfgWdata[NUM_PEND-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendFlags <= '0;
    else       pendFlags <= (pendFlags & ~pendClr) | pendSet;
  end

  assign irq = |(pendFlags & ctrlReg[5:3]);

  // Memory write address and data
  logic [PTR_W-1:0] lowAddr;
  always_comb begin
    unique case (stb.addrSel)
      SEL_HDR0: begin
        lowAddr = hdrPtr;
        memData = pktCnt;
      end
      SEL_HDR1: begin
        lowAddr = advance(hdrPtr, baseReg, boundReg);
        memData = {7'b0, headKind == KIND_ABORT};
      end
      default: begin
        lowAddr = ptrReg;
        memData = fifoMem[rdIdx][7:0];
      end
    endcase
  end

  assign memAddr = {segReg, lowAddr};
  assign curPtr  = ptrReg;
endmodule

// File: rtl/rx_dma_channel.sv
module rx_dma_channel
  import rx_dma_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int PTR_W = 16,
  parameter int REG_W = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int ADDR_W = SEG_W + PTR_W,
  localparam int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic [7:0]          rxData,
  input  logic                rxEnd,
  input  logic                rxAbort,
  input  logic                cfgWe,
  input  logic [2:0]          cfgAddr,
  input  logic [REG_W-1:0]    cfgWdata,
  input  logic                memAck,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [7:0]          memData,
  output logic                irq,
  output logic [NUM_PEND-1:0] pendFlags,
  output logic [PTR_W-1:0]    curPtr
);
  strobe_t          stb;
  kind_t            headKind;
  mode_t            mode;
  logic             fifoEmpty, inPkt, runEn;
  logic [LVL_W-1:0] fifoLevel;

  rx_dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .memAck(memAck), .fifoEmpty(fifoEmpty),
    .headKind(headKind), .inPkt(inPkt), .mode(mode), .runEn(runEn), .stb(stb)
  );

  rx_dma_dp #(
    .SEG_W(SEG_W), .PTR_W(PTR_W), .REG_W(REG_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd),
    .rxAbort(rxAbort), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .stb(stb), .headKind(headKind), .fifoEmpty(fifoEmpty), .inPkt(inPkt),
    .mode(mode), .runEn(runEn), .memAddr(memAddr), .memData(memData), .irq(irq),
    .pendFlags(pendFlags), .curPtr(curPtr), .fifoLevel(fifoLevel)
  );

  assign memReq = stb.memReq;
endmodule

// File: rtl/rx_dma_chk.sv
module rx_dma_chk #(
  parameter int SEG_W = 8,
  parameter int PTR_W = 16,
  parameter int REG_W = 16,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   memReq,
  input logic                   memAck,
  input logic [SEG_W+PTR_W-1:0] memAddr,
  input logic [7:0]             memData,
  input logic                   irq,
  input logic [2:0]             pendFlags,
  input logic                   cfgWe,
  input logic [2:0]             cfgAddr,
  input logic [REG_W-1:0]       cfgWdata,
  input logic                   rxValid,
  input logic [LVL_W-1:0]       fifoLevel
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memData));

  assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pendFlags != 3'b000);

  for (genvar k = 0; k < 3; k++) begin : gSticky
    assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
      pendFlags[k] && !(cfgWe && cfgAddr == 3'd6 && cfgWdata[k]) |=> pendFlags[k]);
  end

  assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && fifoLevel == LVL_W'(DEPTH) |=> pendFlags[2]);

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));
endmodule

bind rx_dma_channel rx_dma_chk #(
  .SEG_W(SEG_W), .PTR_W(PTR_W), .REG_W(REG_W), .DEPTH(DEPTH)
) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memAddr(memAddr),
  .memData(memData), .irq(irq), .pendFlags(pendFlags), .cfgWe(cfgWe),
  .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .rxValid(rxValid), .fifoLevel(fifoLevel)
);

// File: tb/rx_dma_channel_test.sv
module rx_dma_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxEnd = 1'b0, rxAbort = 1'b0;
  logic [7:0]  rxData = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic        memAck = 1'b0;
  logic        memReq, irq;
  logic [23:0] memAddr;
  logic [7:0]  memData;
  logic [2:0]  pendFlags;
  logic [15:0] curPtr;

  always #4 clk = ~clk;

  rx_dma_channel uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxEnd(rxEnd),
    .rxAbort(rxAbort), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .memAck(memAck), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .irq(irq), .pendFlags(pendFlags), .curPtr(curPtr)
  );

  int nChk = 0, nFail = 0;
  logic [31:0] expQ[$];
  string curReq = "R2";
  logic [7:0] seg = 8'h12;
  logic [15:0] base = 16'h0100, bound = 16'h0107, mPtr = 16'h0100;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  function automatic logic [15:0] adv(input logic [15:0] p);
    return (p == bound) ? base : p + 16'd1;
  endfunction

  // Memory responder and scoreboard monitor (R3: ack after 0..2 cycles)
  int dly = 0, ackN = 0;
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
      ackN++;
      dly = ackN % 3;
    end else if (memReq) begin
      if (dly == 0) begin
        if (expQ.size() == 0) begin
          check(0, {curReq, " unexpected write"}, {memAddr, memData}, 0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check({memAddr, memData} == e, curReq, {memAddr, memData}, e);
        end
        memAck = 1'b1;
      end else dly--;
    end
  end

  task automatic cfgWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input bit isEnd, input bit isAbort, input int gap);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxEnd = isEnd; rxAbort = isAbort;
    @(negedge clk);
    rxValid = 1'b0; rxEnd = 1'b0; rxAbort = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expectWr(input logic [15:0] a, input logic [7:0] d);
    expQ.push_back({seg, a, d});
  endtask

  task automatic drain();
    int t = 0;
    while (expQ.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, {curReq, " drain"}, expQ.size(), 0);
  endtask

  // Framed packet: expected model of R5/R6 with R4 wrap
  task automatic sendPacket(input int n, input bit abort, input logic [7:0] seed);
    logic [15:0] hdr;
    hdr = mPtr;
    mPtr = adv(adv(mPtr));
    for (int i = 0; i < n; i++) begin
      expectWr(mPtr, seed + 8'(i));
      mPtr = adv(mPtr);
    end
    expectWr(hdr, 8'(n));
    expectWr(adv(hdr), {7'b0, abort});
    for (int i = 0; i < n; i++) push(seed + 8'(i), 0, 0, 6);
    push(8'h00, !abort, abort, 6);
    drain();
  endtask

  task automatic sendPlain(input logic [7:0] d);
    expectWr(mPtr, d);
    mPtr = adv(mPtr);
    push(d, 0, 0, 2);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R3 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(memReq == 1'b0, "R1 memReq", memReq, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(pendFlags == 3'b0, "R1 pendFlags", pendFlags, 0);
    check(curPtr == 16'h0, "R1 curPtr", curPtr, 0);

    cfgWrite(3'd1, 16'(seg));
    cfgWrite(3'd2, base);
    cfgWrite(3'd3, bound);
    cfgWrite(3'd4, 16'h0100);
    cfgWrite(3'd0, 16'h003C); // framed, run, all enables

    // R2, R3, R5, R6: complete packet
    curReq = "R2/R3/R5/R6";
    sendPacket(3, 0, 8'hA1);
    check(pendFlags == 3'b001, "R6 packet flag", pendFlags, 1);
    check(irq == 1'b1, "R10 irq on packet", irq, 1);
    check(curPtr == mPtr, "R5 curPtr", curPtr, mPtr);
    cfgWrite(3'd6, 16'h0001);
    check(pendFlags == 3'b000, "R10 clear", pendFlags, 0);
    check(irq == 1'b0, "R10 irq cleared", irq, 0);

    // R4, R6: aborted packet that wraps past the bound
    curReq = "R4/R6";
    sendPacket(4, 1, 8'hB0);
    check(pendFlags == 3'b001, "R6 abort flag", pendFlags, 1);
    check(curPtr == mPtr, "R4 wrapped curPtr", curPtr, mPtr);
    cfgWrite(3'd6, 16'h0007);

    // R7 periodic every 3 bytes
    curReq = "R7";
    cfgWrite(3'd4, 16'h0100);
    mPtr = 16'h0100;
    cfgWrite(3'd5, 16'd3);
    cfgWrite(3'd0, 16'h0015); // periodic, run, enable flag 1
    sendPlain(8'h11);
    sendPlain(8'h12);
    check(pendFlags[1] == 1'b0, "R7 before n", pendFlags[1], 0);
    sendPlain(8'h13);
    check(pendFlags[1] == 1'b1, "R7 at n", pendFlags[1], 1);
    check(irq == 1'b1, "R7 irq", irq, 1);
    cfgWrite(3'd6, 16'h0002);
    sendPlain(8'h14);
    sendPlain(8'h15);
    check(pendFlags[1] == 1'b0, "R7 after reload", pendFlags[1], 0);
    sendPlain(8'h16);
    check(pendFlags[1] == 1'b1, "R7 second period", pendFlags[1], 1);
    cfgWrite(3'd6, 16'h0002);

    // R11 timeout mode: markers discarded, no header
    curReq = "R11";
    cfgWrite(3'd0, 16'h0006);
    expectWr(mPtr, 8'h21); mPtr = adv(mPtr);
    expectWr(mPtr, 8'h22); mPtr = adv(mPtr);
    push(8'h21, 0, 0, 4);
    push(8'h00, 1, 0, 4);
    push(8'h22, 0, 0, 4);
    push(8'h00, 0, 1, 4);
    drain();
    check(pendFlags == 3'b000, "R11 no packet flag", pendFlags, 0);
    check(curPtr == mPtr, "R11 curPtr", curPtr, mPtr);

    // R8 run bit off holds writes
    curReq = "R8";
    cfgWrite(3'd0, 16'h0002);
    expectWr(mPtr, 8'h31); mPtr = adv(mPtr);
    expectWr(mPtr, 8'h32); mPtr = adv(mPtr);
    push(8'h31, 0, 0, 0);
    push(8'h32, 0, 0, 20);
    check(memReq == 1'b0, "R8 no request", memReq, 0);
    check(expQ.size() == 2, "R8 nothing written", expQ.size(), 2);
    cfgWrite(3'd0, 16'h0006);
    drain();

    // R9 overrun: six pushes into a stopped channel, four survive
    curReq = "R9";
    cfgWrite(3'd0, 16'h0002);
    for (int i = 0; i < 4; i++) begin
      expectWr(mPtr, 8'h40 + 8'(i));
      mPtr = adv(mPtr);
    end
    for (int i = 0; i < 6; i++) push(8'h40 + 8'(i), 0, 0, 0);
    @(negedge clk);
    check(pendFlags == 3'b100, "R9 overrun flag", pendFlags, 4);
    check(irq == 1'b0, "R10 masked", irq, 0);
    cfgWrite(3'd0, 16'h0022);
    check(irq == 1'b1, "R10 enabled", irq, 1);
    cfgWrite(3'd0, 16'h0026);
    drain();
    check(curPtr == mPtr, "R9 curPtr", curPtr, mPtr);
    cfgWrite(3'd6, 16'h0004);
    check(pendFlags == 3'b000, "R10 overrun cleared", pendFlags, 0);
    check(irq == 1'b0, "R10 irq low", irq, 0);

    summary();
    $finish;
  end
endmodule